// File: doc/BRIEF.md
# Two-Wire Command Frame Decoder

This block is the slave-side receiver for a two-wire serial bus in which a host addresses a small bank of digitally controlled resistor wipers. It samples the bus clock and data lines with the system clock and finds the bus start and stop conditions. It takes bytes in most significant bit first. The first byte of each frame must carry a fixed type code and the board's strap address. The second byte carries a 4-bit opcode, a 2-bit register select and a 2-bit wiper select. The opcode alone sets the length and shape of the rest of the frame.

Transfer opcodes finish after the instruction byte and become a command on the stop condition. Write opcodes take one more byte from the host. Read opcodes return one byte, supplied by a downstream executor, onto the bus. The stepping opcode turns each later clock pulse into a one-step move of the selected wiper, until the frame ends. The decoded command goes to the executor as a one-cycle strobe with its fields held steady. The block never issues a command for a frame that is cut short or that has the wrong address.

Top module: `twowire_cmd_decoder`

## Requirements
- R1: The first byte after a start is accepted only when bits 7:4 equal 0101 and bits 3:0 equal `addr_strap_i`. On a mismatch the block gives no acknowledge and ignores the bus until the next start.
- R2: In the instruction byte, bits 7:4 are the opcode, bits 3:2 the register select and bits 1:0 the wiper select. These appear on `cmd_opcode_o`, `cmd_reg_o` and `cmd_pot_o`.
- R3: For every accepted byte (address, instruction, write data), `sda_pull_o` is high through the ninth clock pulse. It is released after that pulse's falling edge.
- R4: Opcodes 1101, 1110, 0001 and 1000 end after the instruction byte. `cmd_valid_o` pulses once when the stop condition arrives.
- R5: Opcodes 1010 and 1100 take a third byte. That byte is acknowledged and put on `cmd_data_o`, and `cmd_valid_o` pulses after the falling edge of its acknowledge pulse.
- R6: Opcodes 1001 and 1011 pulse `cmd_valid_o` when the last instruction bit is sampled. After the acknowledge, `rd_data_i` is shifted out MSB first, one bit per clock pulse, through pull-low on `sda_pull_o`. After eight bits the line is released.
- R7: Opcode 0010 enters stepping after its acknowledge. Each later clock pulse gives one `step_valid_o` pulse at its falling edge. `step_up_o` is 1 when data was high at that pulse's rising edge and 0 when it was low. Stepping continues until a stop or start and never raises `cmd_valid_o`.
- R8: Opcodes 0000, 0011, 0100 to 0111 and 1111 are not acknowledged and produce no command.
- R9: A start or stop before a frame is complete drops the frame with no command. A start always begins a new address byte.
- R10: `sda_pull_o` changes only while the sampled clock line is low. `cmd_valid_o` lasts one cycle and never coincides with `step_valid_o`.
- R11: After reset, `sda_pull_o`, `cmd_valid_o` and `step_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap_i | input | 4 | Board strap address to match |
| rd_data_i | input | 8 | Byte returned by the executor for read opcodes |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge or a 0 data bit) |
| cmd_valid_o | output | 1 | One-cycle strobe for a decoded command |
| cmd_opcode_o | output | 4 | Decoded opcode |
| cmd_reg_o | output | 2 | Decoded register select |
| cmd_pot_o | output | 2 | Decoded wiper select |
| cmd_data_o | output | 8 | Write data byte |
| step_valid_o | output | 1 | One-cycle strobe for a single wiper step |
| step_up_o | output | 1 | Step direction: 1 up, 0 down |

## Verification
The bench walks every opcode, every strap-address mismatch and every wrong type code, plus all sixteen register/wiper select pairs. A decoder with a wrong opcode class would acknowledge an undefined opcode, wait for a data byte that never comes, or fire its command on the wrong event. The bench cuts frames short with a stop or repeated start at several points, so a design that commits a command early or fails to resynchronise on a mid-byte start shows up as an extra or missing command. Stepping frames end with a stop whose rising clock carries data low, so a design that steps on the rising edge reports a spurious down step.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int SEL_W  = 2;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_INSTR, ST_WDATA, ST_RDATA, ST_HOLD2, ST_STEP, ST_DONE
  } tw_state_e;

  typedef enum logic [2:0] {K_BAD, K_TWO, K_WRITE, K_READ, K_STEP} op_kind_e;

  function automatic op_kind_e op_kind(input logic [NIB_W-1:0] op);
    case (op)
      4'b1101, 4'b1110, 4'b0001, 4'b1000: op_kind = K_TWO;
      4'b1010, 4'b1100:                   op_kind = K_WRITE;
      4'b1001, 4'b1011:                   op_kind = K_READ;
      4'b0010:                            op_kind = K_STEP;
      default:                            op_kind = K_BAD;
    endcase
  endfunction
endpackage

// File: rtl/tw_line_sampler.sv
module tw_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] scl_pipe, sda_pipe;
  logic scl_cur, scl_prv, sda_cur, sda_prv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
      sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
    end
  end

  assign scl_cur = scl_pipe[SYNC_STAGES-1];
  assign scl_prv = scl_pipe[SYNC_STAGES];
  assign sda_cur = sda_pipe[SYNC_STAGES-1];
  assign sda_prv = sda_pipe[SYNC_STAGES];

  assign scl_hi_o = scl_cur;
  assign sda_o    = sda_cur;
  assign rise_o   = scl_cur & ~scl_prv;
  assign fall_o   = ~scl_cur & scl_prv;
  // data edges while the clock stays high mark frame boundaries
  assign start_o  = scl_cur & scl_prv & sda_prv & ~sda_cur;
  assign stop_o   = scl_cur & scl_prv & ~sda_prv & sda_cur;
endmodule

// File: rtl/tw_frame_fsm.sv
module tw_frame_fsm
  import tw_pkg::*;
#(
  parameter logic [NIB_W-1:0] TYPE_CODE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_hi,
  input  logic              sda,
  input  logic              rise,
  input  logic              fall,
  input  logic              start,
  input  logic              stop,
  input  logic [NIB_W-1:0]  addr_strap,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pull,
  output logic              cmd_valid,
  output logic [NIB_W-1:0]  cmd_opcode,
  output logic [SEL_W-1:0]  cmd_reg,
  output logic [SEL_W-1:0]  cmd_pot,
  output logic [BYTE_W-1:0] cmd_data,
  output logic              step_valid,
  output logic              step_up
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_LOW  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_HIGH = CNT_W'(BYTE_W + 1);

  tw_state_e         state_q, state_n;
  op_kind_e          kind_q, kind_n, kind_nx;
  logic [CNT_W-1:0]  bit_q, bit_n;
  logic [BYTE_W-2:0] sh_q, sh_n, tx_q, tx_n;
  logic [BYTE_W-1:0] byte_nx;
  logic              ackp_q, ackp_n, drv_q, drv_n, dir_q, dir_n;
  logic              cv_q, cv_n, sv_q, sv_n, up_q, up_n;
  logic [NIB_W-1:0]  op_q, op_n;
  logic [SEL_W-1:0]  rs_q, rs_n, ps_q, ps_n;
  logic [BYTE_W-1:0] dat_q, dat_n;

  assign byte_nx = {sh_q, sda};
  assign kind_nx = op_kind(byte_nx[BYTE_W-1:BYTE_W-NIB_W]);

  always_comb begin
    state_n = state_q; kind_n = kind_q; bit_n = bit_q; sh_n = sh_q; tx_n = tx_q;
    ackp_n = ackp_q; drv_n = drv_q; dir_n = dir_q; up_n = up_q;
    op_n = op_q; rs_n = rs_q; ps_n = ps_q; dat_n = dat_q;
    cv_n = 1'b0; sv_n = 1'b0;
    if (start) begin
      state_n = ST_ID; bit_n = '0; ackp_n = 1'b0; drv_n = 1'b0;
    end else if (stop) begin
      if (state_q == ST_HOLD2) cv_n = 1'b1;
      state_n = ST_IDLE; ackp_n = 1'b0; drv_n = 1'b0;
    end else begin
      case (state_q)
        ST_ID, ST_INSTR, ST_WDATA: begin
          if (rise) begin
            if (bit_q < ACK_LOW) begin
              sh_n  = byte_nx[BYTE_W-2:0];
              bit_n = bit_q + 1'b1;
              if (bit_q == LAST_BIT) begin
                if (state_q == ST_ID) begin
                  if (byte_nx == {TYPE_CODE, addr_strap}) ackp_n = 1'b1;
                  else state_n = ST_IDLE;
                end else if (state_q == ST_INSTR) begin
                  if (kind_nx == K_BAD) state_n = ST_IDLE;
                  else begin
                    ackp_n = 1'b1; kind_n = kind_nx;
                    op_n = byte_nx[7:4]; rs_n = byte_nx[3:2]; ps_n = byte_nx[1:0];
                    if (kind_nx == K_READ) cv_n = 1'b1;
                  end
                end else begin
                  ackp_n = 1'b1; dat_n = byte_nx;
                end
              end
            end else begin
              bit_n = ACK_HIGH;
            end
          end else if (fall) begin
            if (bit_q == ACK_LOW && ackp_q) begin
              drv_n = 1'b1;
            end else if (bit_q == ACK_HIGH) begin
              drv_n = 1'b0; ackp_n = 1'b0; bit_n = '0;
              if (state_q == ST_ID) state_n = ST_INSTR;
              else if (state_q == ST_WDATA) begin
                cv_n = 1'b1; state_n = ST_DONE;
              end else begin
                case (kind_q)
                  K_TWO:   state_n = ST_HOLD2;
                  K_WRITE: state_n = ST_WDATA;
                  K_STEP:  state_n = ST_STEP;
                  K_READ: begin
                    state_n = ST_RDATA;
                    drv_n   = ~rd_data[BYTE_W-1];
                    tx_n    = rd_data[BYTE_W-2:0];
                  end
                  default: state_n = ST_IDLE;
                endcase
              end
            end
          end
        end
        ST_RDATA: begin
          if (rise && bit_q < ACK_LOW) bit_n = bit_q + 1'b1;
          else if (fall) begin
            if (bit_q == ACK_LOW) begin
              drv_n = 1'b0; state_n = ST_DONE;
            end else begin
              drv_n = ~tx_q[BYTE_W-2];
              tx_n  = {tx_q[BYTE_W-3:0], 1'b0};
            end
          end
        end
        ST_STEP: begin
          if (rise) dir_n = sda;
          else if (fall) begin
            sv_n = 1'b1; up_n = dir_q;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; kind_q <= K_BAD; bit_q <= '0; sh_q <= '0; tx_q <= '0;
      ackp_q <= 1'b0; drv_q <= 1'b0; dir_q <= 1'b0; up_q <= 1'b0;
      cv_q <= 1'b0; sv_q <= 1'b0;
      op_q <= '0; rs_q <= '0; ps_q <= '0; dat_q <= '0;
    end else begin
      state_q <= state_n; kind_q <= kind_n; bit_q <= bit_n; sh_q <= sh_n; tx_q <= tx_n;
      ackp_q <= ackp_n; drv_q <= drv_n; dir_q <= dir_n; up_q <= up_n;
      cv_q <= cv_n; sv_q <= sv_n;
      op_q <= op_n; rs_q <= rs_n; ps_q <= ps_n; dat_q <= dat_n;
    end
  end

  assign sda_pull   = drv_q;
  assign cmd_valid  = cv_q;
  assign cmd_opcode = op_q;
  assign cmd_reg    = rs_q;
  assign cmd_pot    = ps_q;
  assign cmd_data   = dat_q;
  assign step_valid = sv_q;
  assign step_up    = up_q;

  // R10: the data line is only moved while the clock line is low
  a_r10_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv_q) |-> !scl_hi);
  // R10: command strobe lasts a single cycle
  a_r10_cmd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cv_q |=> !cv_q);
  // R10: command and step strobes never coincide
  a_r10_cmd_step_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cv_q, sv_q}));
  // R7: steps only come from the stepping opcode
  a_r7_step_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    sv_q |-> op_q == 4'b0010);
  // R4: a command strobe only carries a defined non-stepping opcode
  a_r4_cmd_kind: assert property (@(posedge clk) disable iff (!rst_n)
    cv_q |-> (op_kind(op_q) != K_BAD && op_kind(op_q) != K_STEP));
endmodule

// File: rtl/twowire_cmd_decoder.sv
module twowire_cmd_decoder
  import tw_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [NIB_W-1:0] TYPE_CODE   = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [NIB_W-1:0]  addr_strap_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_pull_o,
  output logic              cmd_valid_o,
  output logic [NIB_W-1:0]  cmd_opcode_o,
  output logic [SEL_W-1:0]  cmd_reg_o,
  output logic [SEL_W-1:0]  cmd_pot_o,
  output logic [BYTE_W-1:0] cmd_data_o,
  output logic              step_valid_o,
  output logic              step_up_o
);
  logic scl_hi, sda_s, rise, fall, start, stop;

  tw_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi_o(scl_hi), .sda_o(sda_s), .rise_o(rise), .fall_o(fall),
    .start_o(start), .stop_o(stop)
  );

  tw_frame_fsm #(.TYPE_CODE(TYPE_CODE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_hi(scl_hi), .sda(sda_s),
    .rise(rise), .fall(fall), .start(start), .stop(stop),
    .addr_strap(addr_strap_i), .rd_data(rd_data_i),
    .sda_pull(sda_pull_o), .cmd_valid(cmd_valid_o),
    .cmd_opcode(cmd_opcode_o), .cmd_reg(cmd_reg_o), .cmd_pot(cmd_pot_o),
    .cmd_data(cmd_data_o), .step_valid(step_valid_o), .step_up(step_up_o)
  );
endmodule

// File: tb/tb_twowire_cmd_decoder.sv
`timescale 1ns/1ps
module tb_twowire_cmd_decoder;
  localparam logic [3:0] STRAP = 4'b1010;
  localparam int Q = 8;
  localparam int H = 16;

  logic clk, rst_n, scl, sda_m;
  logic [3:0] strap;
  logic [7:0] rd_data;
  logic sda_pull, cmd_valid, step_valid, step_up;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg, cmd_pot;
  logic [7:0] cmd_data;
  logic sda_line;

  assign sda_line = sda_m & ~sda_pull;

  twowire_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_strap_i(strap), .rd_data_i(rd_data), .sda_pull_o(sda_pull),
    .cmd_valid_o(cmd_valid), .cmd_opcode_o(cmd_op), .cmd_reg_o(cmd_reg),
    .cmd_pot_o(cmd_pot), .cmd_data_o(cmd_data), .step_valid_o(step_valid),
    .step_up_o(step_up)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_err = 0, n_cmd = 0, n_up = 0, n_dn = 0;
  int long_cv = 0, bad_pull = 0, cyc = 0;
  logic done = 1'b0;
  logic prev_cv = 1'b0, prev_pull = 1'b0;
  logic [3:0] last_op;
  logic [1:0] last_reg, last_pot;
  logic [7:0] last_data;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin
        n_cmd++; last_op = cmd_op; last_reg = cmd_reg; last_pot = cmd_pot; last_data = cmd_data;
        if (prev_cv) long_cv++;
      end
      if (step_valid) begin
        if (step_up) n_up++; else n_dn++;
      end
      if (sda_pull != prev_pull && scl) bad_pull++;
      prev_cv = cmd_valid; prev_pull = sda_pull;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wclk(Q); scl = 1'b1; wclk(H); scl = 1'b0; wclk(Q);
  endtask

  task automatic start_c;
    sda_m = 1'b1; wclk(Q); scl = 1'b1; wclk(H); sda_m = 1'b0; wclk(H); scl = 1'b0; wclk(Q);
  endtask

  task automatic stop_c;
    sda_m = 1'b0; wclk(Q); scl = 1'b1; wclk(H); sda_m = 1'b1; wclk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wclk(Q); scl = 1'b1; wclk(H/2);
    ack = ~sda_line;
    wclk(H/2); scl = 1'b0; wclk(Q);
  endtask

  task automatic read_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wclk(Q); scl = 1'b1; wclk(H/2); b[i] = sda_line; wclk(H/2); scl = 1'b0;
    end
    wclk(Q);
    send_bit(1'b1);
  endtask

  function automatic int exp_kind(input logic [3:0] op);
    case (op)
      4'b1101, 4'b1110, 4'b0001, 4'b1000: return 1;
      4'b1010, 4'b1100: return 2;
      4'b1001, 4'b1011: return 3;
      4'b0010: return 4;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired (R1..R11 incomplete)");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int c0, u0, d0;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; strap = STRAP; rd_data = 8'h00;
    wclk(5); rst_n = 1'b1; wclk(5);
    chk(!sda_pull && !cmd_valid && !step_valid, "R11 reset outputs", {sda_pull, cmd_valid, step_valid}, 0);

    // R1: address sweep and type sweep
    for (int a = 0; a < 16; a++) begin
      c0 = n_cmd;
      start_c; send_byte({4'b0101, 4'(a)}, ack);
      chk(ack == (4'(a) == STRAP), "R1 address match ack", ack, 4'(a) == STRAP);
      send_byte(8'hD5, ack);
      stop_c; wclk(4);
      chk(n_cmd == c0 + ((4'(a) == STRAP) ? 1 : 0), "R1 mismatched frame ignored", n_cmd, c0);
    end
    for (int t = 0; t < 16; t++) begin
      start_c; send_byte({4'(t), STRAP}, ack);
      chk(ack == (t == 5), "R1 type code ack", ack, t == 5);
      stop_c;
    end

    // opcode sweep: R3 R4 R5 R6 R7 R8
    for (int op = 0; op < 16; op++) begin
      logic [3:0] o;
      int k;
      o = 4'(op); k = exp_kind(o);
      c0 = n_cmd; u0 = n_up; d0 = n_dn;
      rd_data = {o, ~o};
      start_c; send_byte({4'b0101, STRAP}, ack);
      chk(ack, "R3 address ack", ack, 1);
      send_byte({o, 2'b01, 2'b10}, ack);
      chk(ack == (k != 0), "R8 instruction ack by opcode class", ack, k != 0);
      if (k == 2) begin
        send_byte({~o, o}, ack);
        chk(ack, "R5 data byte ack", ack, 1);
      end else if (k == 3) begin
        read_byte(rb);
        chk(rb == {o, ~o}, "R6 returned byte", rb, {o, ~o});
      end else if (k == 4) begin
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      end
      stop_c; wclk(4);
      chk(n_cmd == c0 + ((k >= 1 && k <= 3) ? 1 : 0), "R4 command count per opcode", n_cmd - c0, (k >= 1 && k <= 3));
      if (k >= 1 && k <= 3)
        chk(last_op == o && last_reg == 2'b01 && last_pot == 2'b10, "R2 decoded fields",
            {last_op, last_reg, last_pot}, {o, 4'b0110});
      if (k == 2) chk(last_data == {~o, o}, "R5 write data", last_data, {~o, o});
      if (k == 4) chk(n_up == u0 + 2 && n_dn == d0 + 1, "R7 step counts", (n_up - u0) * 16 + (n_dn - d0), 8'h21);
      chk(!sda_pull, "R3 line released after frame", sda_pull, 0);
    end

    // R2 select sweep on a two-byte transfer
    for (int rp = 0; rp < 16; rp++) begin
      c0 = n_cmd;
      start_c; send_byte({4'b0101, STRAP}, ack); send_byte({4'b1110, 4'(rp)}, ack); stop_c; wclk(4);
      chk(n_cmd == c0 + 1 && {last_reg, last_pot} == 4'(rp), "R2 select fields", {last_reg, last_pot}, rp);
    end

    // R9 aborts
    c0 = n_cmd;
    start_c; send_byte({4'b0101, STRAP}, ack); send_byte(8'hE0, ack); start_c; stop_c; wclk(4);
    chk(n_cmd == c0, "R9 repeated start drops transfer", n_cmd - c0, 0);
    start_c; send_byte({4'b0101, STRAP}, ack); send_byte(8'hC3, ack); stop_c; wclk(4);
    chk(n_cmd == c0, "R9 stop before write data", n_cmd - c0, 0);
    start_c; send_byte({4'b0101, STRAP}, ack);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    start_c; send_byte({4'b0101, STRAP}, ack);
    chk(ack, "R9 restart mid byte resyncs", ack, 1);
    send_byte(8'hA7, ack); send_byte(8'h3C, ack); stop_c; wclk(4);
    chk(n_cmd == c0 + 1 && last_op == 4'hA && last_data == 8'h3C, "R9 frame after restart", last_data, 8'h3C);
    u0 = n_up; d0 = n_dn;
    start_c; send_byte({4'b0101, STRAP}, ack); send_byte(8'h21, ack);
    send_bit(1'b1); start_c; stop_c; wclk(4);
    chk(n_up == u0 + 1 && n_dn == d0 && n_cmd == c0 + 1, "R7 stepping ends on start", n_dn - d0, 0);

    chk(long_cv == 0, "R10 command strobe single cycle", long_cv, 0);
    chk(bad_pull == 0, "R10 pull changes only with clock low", bad_pull, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule